// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block sits between a small processor and a byte-wide nonvolatile data store on the same chip. The store is modelled as a register array. The processor reaches the block through three byte-wide registers, chosen by a two-bit select: an address register, a data register and a control register. The control register carries two strobe bits that clear themselves. Setting the program strobe copies the data register into the addressed location. The program strobe then stays set for a long programming interval, measured by a timer in clock cycles, and software can poll it. Setting the fetch strobe loads the addressed byte into the data register.

Each accepted strobe raises a processor stall output for a fixed number of cycles: two for a program and four for a fetch. A fetch always finishes inside its stall, so software never has to poll the fetch strobe. While a program is running, the block ignores new strobes and keeps the address and data registers frozen, so the byte being programmed cannot change under it. The programming interval follows a supply-range input that is sampled when the program starts. Reset stops everything except the stored bytes, which survive it.

Top module: `nvbyte_access_ctrl`

## Requirements
- R1: Select code 0 is the address register, 1 the data register, 2 the control register and 3 unused (reads return 0, writes are dropped). The address register is 6 bits wide. A written byte keeps only bits 5:0, and reading the register returns the address zero-extended.
- R2: A control write with bit 1 set, while the block is idle, starts a program. When the program strobe clears, the array location given by the address register holds the data register value.
- R3: Control bit 1 reads back as 1 for exactly `access_ticks(CLK_KHZ, HI_US)` cycles after the accepting edge when `low_vcc` was 0 at the start, and for `access_ticks(CLK_KHZ, LO_US)` cycles when it was 1. `access_ticks` is kHz*us/1000, with a minimum of 1.
- R4: After an accepted program strobe, `cpu_stall` is high for exactly 2 cycles, starting in the cycle after the accepting edge.
- R5: A control write with bit 0 set (and bit 1 clear), while the block is idle, starts a fetch. One cycle later control bit 0 reads back as 0, and the data register holds the addressed array byte.
- R6: After an accepted fetch strobe, `cpu_stall` is high for exactly 4 cycles, starting in the cycle after the accepting edge.
- R7: While control bit 1 is set, writes to the address, data and control registers have no effect, and the array is written only with the values latched at the start of the program.
- R8: A control write with both bits set starts a program only. The fetch is dropped, the stall lasts 2 cycles and the data register is not reloaded.
- R9: Reset clears both strobes, the address and data registers, the stall and the program timer. A program that reset cuts short writes nothing, and array contents are kept through reset.
- R10: A control write with bits 1:0 both zero starts nothing and does not raise `cpu_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| low_vcc | input | 1 | Selects the longer programming interval, sampled when a program starts |
| reg_wr | input | 1 | Register write enable from the processor |
| reg_sel | input | 2 | Register select (0 address, 1 data, 2 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| cpu_stall | output | 1 | Processor stall request |

## Verification
On every cycle, assertions check the exact stall shapes for program and fetch starts, that the fetch strobe lasts a single cycle, that a running program holds its strobe until the timer reports done, that the address and data registers stay frozen while a program runs, and that a combined strobe never starts a fetch. The bench scenarios show what a property cannot: that the programmed byte lands in the right masked location, how long the programming interval is for each supply setting, that a program cut short by reset writes nothing while earlier bytes persist, and the random mix of programs and fetches checked against a model of the array.

// File: rtl/nvac_pkg.sv
package nvac_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int FETCH_BIT = 0;
  localparam int PROG_BIT  = 1;

  localparam int PROG_STALL  = 2;
  localparam int FETCH_STALL = 4;

  // Programming interval in clock cycles, from clock rate and interval length.
  function automatic int unsigned access_ticks(int unsigned khz, int unsigned us);
    int unsigned t;
    t = (khz * us) / 1000;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/nvac_store.sv
module nvac_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  // No reset: contents persist across reset.
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/nvac_wtimer.sv
module nvac_wtimer #(
  parameter int unsigned HI_TICKS = 2500,
  parameter int unsigned LO_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic low_vcc,
  output logic busy,
  output logic done
);
  localparam int unsigned MAXT = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS;
  localparam int TW = $clog2(MAXT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= low_vcc ? TW'(LO_TICKS) : TW'(HI_TICKS);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);
  assign done = (cnt_q == TW'(1));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

endmodule

// File: rtl/nvac_stall.sv
module nvac_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_go,
  input  logic fetch_go,
  output logic stall
);
  import nvac_pkg::*;

  logic [2:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (prog_go)    cnt_q <= 3'(PROG_STALL);
    else if (fetch_go)   cnt_q <= 3'(FETCH_STALL);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign stall = (cnt_q != 0);

  assert_prog_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> stall ##1 stall ##1 !stall);
  assert_fetch_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !prog_go) |=> stall ##1 stall ##1 stall ##1 stall ##1 !stall);

endmodule

// File: rtl/nvbyte_access_ctrl.sv
module nvbyte_access_ctrl #(
  parameter int unsigned CLK_KHZ = 1000,
  parameter int unsigned HI_US   = 2500,
  parameter int unsigned LO_US   = 4000,
  parameter int          AW      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_vcc,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_stall
);
  import nvac_pkg::*;

  localparam int unsigned HI_T = access_ticks(CLK_KHZ, HI_US);
  localparam int unsigned LO_T = access_ticks(CLK_KHZ, LO_US);

  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          fetch_q;
  logic          prog_busy, prog_done;
  logic [7:0]    mem_rdata;

  // Named internal events
  logic ctrl_wr, locked, prog_go, fetch_go, addr_wr, data_wr;

  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign locked   = prog_busy || fetch_q || cpu_stall;
  assign prog_go  = ctrl_wr && !locked && reg_wdata[PROG_BIT];
  assign fetch_go = ctrl_wr && !locked && reg_wdata[FETCH_BIT] && !reg_wdata[PROG_BIT];
  assign addr_wr  = reg_wr && (reg_sel == SEL_ADDR) && !prog_busy;
  assign data_wr  = reg_wr && (reg_sel == SEL_DATA) && !prog_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= fetch_go;
      if (addr_wr) addr_q <= reg_wdata[AW-1:0];
      if (fetch_q)      data_q <= mem_rdata;
      else if (data_wr) data_q <= reg_wdata;
    end
  end

  nvac_wtimer #(.HI_TICKS(HI_T), .LO_TICKS(LO_T)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_go), .low_vcc(low_vcc),
    .busy(prog_busy), .done(prog_done)
  );

  nvac_stall u_stall (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .fetch_go(fetch_go),
    .stall(cpu_stall)
  );

  nvac_store #(.AW(AW), .DW(8)) u_store (
    .clk(clk), .we(prog_done), .waddr(addr_q), .wdata(data_q),
    .raddr(addr_q), .rdata(mem_rdata)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR: reg_rdata = 8'(addr_q);
      SEL_DATA: reg_rdata = data_q;
      SEL_CTRL: reg_rdata = {6'b0, prog_busy, fetch_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assert_frozen_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |=> ($stable(addr_q) && $stable(data_q)));
  assert_fetch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |=> !fetch_q);
  assert_prog_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> (!fetch_q && prog_busy));
  assert_no_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[1:0] == 2'b00 && !cpu_stall && !prog_busy) |=> !cpu_stall);

endmodule

// File: tb/tb_nvbyte_access_ctrl.sv
module tb_nvbyte_access_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned KHZ = 100;
  localparam int unsigned HUS = 2500;
  localparam int unsigned LUS = 4000;

  logic clk = 0, rst_n = 0, low_vcc = 0, reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cpu_stall;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] model [64];

  nvbyte_access_ctrl #(.CLK_KHZ(KHZ), .HI_US(HUS), .LO_US(LUS)) dut (
    .clk(clk), .rst_n(rst_n), .low_vcc(low_vcc), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_ticks(bit lv);
    int t;
    t = int'(((lv ? LUS : HUS) * KHZ) / 1000);
    return (t < 1) ? 1 : t;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] s, logic [7:0] v);
    @(negedge clk);
    reg_sel = s; reg_wdata = v; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic bus_read(logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  // Program one byte, measuring stall (R4) and busy length (R3).
  task automatic do_prog(logic [5:0] a, logic [7:0] d, bit lv);
    logic [7:0] c;
    int n;
    bus_write(2'd0, {2'b00, a});
    bus_write(2'd1, d);
    low_vcc = lv;
    bus_write(2'd2, 8'h02);
    n = 0;
    bus_read(2'd2, c);
    while (c[1] && n < 1000) begin
      n++;
      if (n <= 3) check("R4 stall", int'(cpu_stall), (n <= 2) ? 1 : 0);
      @(negedge clk);
      bus_read(2'd2, c);
    end
    check("R3 busy cycles", n, exp_ticks(lv));
    model[a] = d;
  endtask

  // Fetch one byte, measuring stall (R6) and result (R5).
  task automatic do_fetch(logic [5:0] a);
    logic [7:0] c, v;
    int n;
    bus_write(2'd0, {2'b00, a});
    bus_write(2'd2, 8'h01);
    n = 0;
    while (cpu_stall && n < 10) begin n++; @(negedge clk); end
    check("R6 fetch stall", n, 4);
    bus_read(2'd2, c);
    check("R5 fetch strobe clear", int'(c[0]), 0);
    bus_read(2'd1, v);
    check("R5 fetch data", int'(v), int'(model[a]));
  endtask

  initial begin
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected below 200000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int dummy;
    dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    bus_read(2'd2, v); check("R9 ctrl after reset", int'(v), 0);
    check("R9 stall after reset", int'(cpu_stall), 0);
    bus_read(2'd0, v); check("R9 addr after reset", int'(v), 0);
    // R1 masking and unused select
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, v); check("R1 addr mask", int'(v), 8'h3F);
    bus_write(2'd3, 8'h55);
    bus_read(2'd3, v); check("R1 unused select", int'(v), 0);
    // R10 empty control write
    bus_write(2'd2, 8'h00);
    check("R10 no stall", int'(cpu_stall), 0);
    bus_read(2'd2, v); check("R10 ctrl idle", int'(v), 0);
    // R2 directed program and fetch, both supply settings
    do_prog(6'd5, 8'hA5, 0);
    do_fetch(6'd5);
    do_prog(6'd63, 8'h3C, 1);
    do_fetch(6'd63);
    // R2 masking of upper bits to the array
    bus_write(2'd0, 8'hC7);
    bus_write(2'd1, 8'h99);
    bus_write(2'd2, 8'h02);
    while (cpu_stall) @(negedge clk);
    begin : wait_busy
      bus_read(2'd2, v);
      while (v[1]) begin @(negedge clk); bus_read(2'd2, v); end
    end
    model[7] = 8'h99;
    do_fetch(6'd7);
    // R7 writes during a program are ignored
    bus_write(2'd0, 8'd10);
    bus_write(2'd1, 8'h11);
    bus_write(2'd2, 8'h02);
    @(negedge clk); @(negedge clk);
    bus_write(2'd0, 8'd20);
    bus_write(2'd1, 8'h22);
    bus_write(2'd2, 8'h01);
    bus_read(2'd0, v); check("R7 addr frozen", int'(v), 10);
    bus_read(2'd1, v); check("R7 data frozen", int'(v), 8'h11);
    bus_read(2'd2, v); check("R7 ctrl unchanged", int'(v), 2);
    check("R7 no new stall", int'(cpu_stall), 0);
    bus_read(2'd2, v);
    while (v[1]) begin @(negedge clk); bus_read(2'd2, v); end
    model[10] = 8'h11;
    model[20] = 8'h00;
    do_prog(6'd20, 8'h00, 0);
    do_fetch(6'd10);
    // R8 both strobes at once
    bus_write(2'd0, 8'd30);
    bus_write(2'd1, 8'h77);
    bus_write(2'd2, 8'h03);
    check("R8 stall c1", int'(cpu_stall), 1);
    bus_read(2'd2, v); check("R8 prog only", int'(v), 2);
    @(negedge clk); check("R8 stall c2", int'(cpu_stall), 1);
    @(negedge clk); check("R8 stall ends", int'(cpu_stall), 0);
    bus_read(2'd1, v); check("R8 data not reloaded", int'(v), 8'h77);
    bus_read(2'd2, v);
    while (v[1]) begin @(negedge clk); bus_read(2'd2, v); end
    model[30] = 8'h77;
    do_fetch(6'd30);
    // R9 reset aborts a program, array survives
    bus_write(2'd0, 8'd5);
    bus_write(2'd1, 8'hEE);
    bus_write(2'd2, 8'h02);
    repeat (20) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bus_read(2'd2, v); check("R9 strobe cleared", int'(v), 0);
    check("R9 stall cleared", int'(cpu_stall), 0);
    repeat (300) @(negedge clk);
    do_fetch(6'd5);
    do_fetch(6'd63);
    // Random mix
    for (int i = 0; i < 20; i++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = 6'($urandom_range(0, 63));
      d = 8'($urandom_range(0, 255));
      do_prog(a, d, bit'($urandom_range(0, 1)));
      do_fetch(a);
    end
    do_fetch(6'd10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule